// File: doc/BRIEF.md
# PRBS Link Test Generator

This block sits on the readout data path just ahead of the serializer. In normal operation it passes detector words through to its output. A single toggle command switches it into a link-test mode. In that mode each word slot carries the next word of a 16-bit maximal-length pseudo-random sequence instead of detector data. The receiving end can predict that sequence and count bit errors on the link. The same command, issued again, hands the data path back to the detector words.

Word slots are marked by a one-cycle strobe. A change of source always takes effect on a slot boundary, so no word is ever mixed from two sources. Every entry into the test mode starts the sequence from a fixed non-zero seed. The generator advances only on slots it actually emits, so idle cycles between slots do not disturb the sequence the receiver expects. Serialization, line coding and packet framing are handled elsewhere. This block delivers parallel words with a valid strobe.

Top module: `prbs_link_gen`

## Requirements
- R1: After synchronous active-low reset, `out_valid` is 0, `out_data` is 0 and the block is in normal (pass-through) mode.
- R2: In normal mode, a cycle with `slot_tick`=1 and `norm_valid`=1 gives `out_valid`=1 and `out_data`=`norm_data` in the next cycle. A slot with `norm_valid`=0 gives `out_valid`=0 and leaves `out_data` unchanged.
- R3: In a cycle with `slot_tick`=0, `out_valid` is 0 in the next cycle and `out_data` keeps its value, in either mode.
- R4: A cycle with `cmd_toggle`=1 flips the requested mode. The new mode governs the first slot in a later cycle; a slot in the same cycle as the command still uses the old mode.
- R5: The first test-mode word after entering the mode is the seed 0xACE1, and it is emitted with `out_valid`=1.
- R6: Each later test-mode word w' is derived from the previous one w as w' = {w[14:0], w[15]^w[13]^w[12]^w[10]}. This is the polynomial x^16+x^14+x^13+x^11+1.
- R7: The sequence has a period of exactly 65535 slots: the seed reappears first at the 65536th consecutive test slot, and the generator state is never zero.
- R8: After a stop command, the next slot carries normal data again. A later start restarts the sequence from the seed.
- R9: The sequence advances only on test-mode slots. Cycles without a slot, of any number, do not change which word comes next.
- R10: In test mode every slot is emitted with `out_valid`=1, and `norm_data` and `norm_valid` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_toggle | input | 1 | One-cycle command that flips between normal and test mode |
| slot_tick | input | 1 | Marks a word slot (word boundary) |
| norm_valid | input | 1 | Normal data word present for this slot |
| norm_data | input | 16 | Normal detector data word |
| out_valid | output | 1 | Output word valid (one cycle per emitted slot) |
| out_data | output | 16 | Output word, held between slots |

## Verification
The bench builds the block with its default parameters: a 16-bit word, tap mask 0xB400 and seed 0xACE1. With these values a complete period of 65535 slots fits in a single directed run, so the exact period and the seed's first return are checked directly rather than inferred. The random phase then mixes sparse toggle commands, irregular slot spacing and random normal words. This reaches commands that coincide with slots, stops and restarts in quick succession, and long gaps between slots.

// File: rtl/prbs_link_pkg.sv
// Shared types for the PRBS link test generator.
// Assumes: nothing beyond a single clock domain.
package prbs_link_pkg;

    // Source currently selected for the output word
    typedef enum logic {
        SRC_NORMAL = 1'b0,
        SRC_PRBS   = 1'b1
    } src_sel_e;

endpackage

// File: rtl/prbs_cmd_ctrl.sv
// Mode control: turns toggle commands into a requested source and flags the
// first test slot after each entry into test mode.
// Assumes: cmd_toggle is a single-cycle pulse; a slot in the command cycle
// still uses the old mode.
module prbs_cmd_ctrl
    import prbs_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_toggle,
    input  logic     slot_tick,
    output src_sel_e sel,
    output logic     restart
);

    logic req_q;
    logic active_q;

    // Requested mode flips on each command
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (cmd_toggle)
            req_q <= ~req_q;
    end

    // Remembers the mode used by the most recent slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (slot_tick)
            active_q <= req_q;
    end

    // Decode selected source and first-word condition
    always_comb begin
        sel     = req_q ? SRC_PRBS : SRC_NORMAL;
        restart = req_q & ~active_q;
    end

endmodule

// File: rtl/prbs_lfsr.sv
// Fibonacci LFSR word source. Presents the word to emit this slot: the seed
// on a restart, otherwise the stored state. On advance, stores the successor
// of the emitted word.
// Assumes: TAP_MASK describes a maximal-length polynomial and SEED is non-zero.
module prbs_lfsr #(
    parameter int               WIDTH    = 16,
    parameter logic [WIDTH-1:0] TAP_MASK = 16'hB400,
    parameter logic [WIDTH-1:0] SEED     = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             restart,
    output logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] state
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] succ;

    // Word for this slot and its successor
    always_comb begin
        word = restart ? SEED : state_q;
        succ = {word[MSB-1:0], ^(word & TAP_MASK)};
    end

    // State steps only when a test word is emitted
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (advance)
            state_q <= succ;
    end

    assign state = state_q;

endmodule

// File: rtl/prbs_out_mux.sv
// Registered output stage: on each slot picks either the PRBS word or the
// normal word. Between slots, valid drops and data holds.
// Assumes: slot_tick marks word boundaries.
module prbs_out_mux
    import prbs_link_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  src_sel_e         sel,
    input  logic [WIDTH-1:0] prbs_word,
    input  logic             norm_valid,
    input  logic [WIDTH-1:0] norm_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);

    // Output register updated at word boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (slot_tick && sel == SRC_PRBS) begin
            out_valid <= 1'b1;
            out_data  <= prbs_word;
        end else if (slot_tick) begin
            out_valid <= norm_valid;
            if (norm_valid)
                out_data <= norm_data;
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/prbs_link_gen.sv
// Top of the PRBS link test generator. A toggle command swaps the output
// between normal data and a maximal-length pseudo-random word sequence.
// Swaps take effect at word boundaries.
// Assumes: one word slot per slot_tick pulse; single clock domain.
module prbs_link_gen
    import prbs_link_pkg::*;
#(
    parameter int               WIDTH    = 16,
    parameter logic [WIDTH-1:0] TAP_MASK = 16'hB400,
    parameter logic [WIDTH-1:0] SEED     = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_toggle,
    input  logic             slot_tick,
    input  logic             norm_valid,
    input  logic [WIDTH-1:0] norm_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);

    src_sel_e         sel;
    logic             restart;
    logic             use_prbs;
    logic             advance;
    logic [WIDTH-1:0] prbs_word;
    logic [WIDTH-1:0] lfsr_state;

    prbs_cmd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_toggle (cmd_toggle),
        .slot_tick  (slot_tick),
        .sel        (sel),
        .restart    (restart)
    );

    // Generator steps on every slot spent in test mode
    always_comb begin
        use_prbs = (sel == SRC_PRBS);
        advance  = slot_tick & use_prbs;
    end

    prbs_lfsr #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK),
        .SEED     (SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .restart (restart),
        .word    (prbs_word),
        .state   (lfsr_state)
    );

    prbs_out_mux #(
        .WIDTH (WIDTH)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_tick  (slot_tick),
        .sel        (sel),
        .prbs_word  (prbs_word),
        .norm_valid (norm_valid),
        .norm_data  (norm_data),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

endmodule

// File: rtl/prbs_link_gen_chk.sv
// Assertion checker for prbs_link_gen, attached by bind.
// Assumes: reset is held low from time zero for at least one clock edge.
module prbs_link_gen_chk #(
    parameter int               WIDTH    = 16,
    parameter logic [WIDTH-1:0] TAP_MASK = 16'hB400
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_toggle,
    input logic             slot_tick,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_data,
    input logic             use_prbs,
    input logic [WIDTH-1:0] lfsr_state
);

    function automatic logic [WIDTH-1:0] succ_of(input logic [WIDTH-1:0] w);
        return {w[WIDTH-2:0], ^(w & TAP_MASK)};
    endfunction

    // R3: no slot means no valid word and held data
    p_gap_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> (!out_valid && $stable(out_data)));

    // R4: a command flips the requested mode
    p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_toggle |=> (use_prbs != $past(use_prbs)));

    // R4: no command, no mode change
    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_toggle |=> $stable(use_prbs));

    // R10: every test slot produces a valid word
    p_test_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && use_prbs) |=> out_valid);

    // R6: stored state is the successor of the word just emitted
    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && use_prbs) |=> (lfsr_state == succ_of(out_data)));

    // R9: generator frozen outside test slots
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_tick && use_prbs) |=> $stable(lfsr_state));

    // R7: generator never enters the all-zero lock-up state
    p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

endmodule

bind prbs_link_gen prbs_link_gen_chk #(
    .WIDTH    (WIDTH),
    .TAP_MASK (TAP_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_toggle (cmd_toggle),
    .slot_tick  (slot_tick),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .use_prbs   (use_prbs),
    .lfsr_state (lfsr_state)
);

// File: tb/tb_prbs_link_gen.sv
`timescale 1ns/1ps
module tb_prbs_link_gen;

    localparam logic [15:0] SEED = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_toggle = 1'b0;
    logic        slot_tick = 1'b0;
    logic        norm_valid = 1'b0;
    logic [15:0] norm_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Reference model state
    logic        m_req = 0, m_act = 0, m_valid = 0;
    logic [15:0] m_data = '0, m_lfsr = SEED;

    always #2 clk = ~clk;

    prbs_link_gen dut (
        .clk(clk), .rst_n(rst_n), .cmd_toggle(cmd_toggle), .slot_tick(slot_tick),
        .norm_valid(norm_valid), .norm_data(norm_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    // R6 successor rule
    function automatic logic [15:0] nxt(input logic [15:0] w);
        return {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
    endfunction

    task automatic check_eq(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got valid/data=%h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic c, input logic s, input logic v, input logic [15:0] d);
        string tag;
        logic [15:0] w;
        cmd_toggle = c; slot_tick = s; norm_valid = v; norm_data = d;
        @(posedge clk);
        if (!s) tag = "R3";
        else if (m_req && !m_act) tag = "R5";
        else if (m_req) tag = "R6";
        else tag = "R2";
        if (s) begin
            if (m_req) begin
                w = m_act ? m_lfsr : SEED;
                m_data = w; m_valid = 1; m_lfsr = nxt(w); m_act = 1;
            end else begin
                m_valid = v;
                if (v) m_data = d;
                m_act = 0;
            end
        end else begin
            m_valid = 0;
        end
        if (c) m_req = ~m_req;
        @(negedge clk);
        check_eq(tag, {out_valid, out_data}, {m_valid, m_data});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int first_ret;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", {out_valid, out_data}, 17'h0);
        rst_n = 1'b1;
        step(0, 0, 0, 16'h0);
        check_eq("R1", {out_valid, out_data}, 17'h0);
        // R1/R2: starts in pass-through
        step(0, 1, 1, 16'h1234);
        check_eq("R2", {out_valid, out_data}, {1'b1, 16'h1234});
        step(0, 1, 0, 16'h9999);
        check_eq("R2", {out_valid, out_data}, {1'b0, 16'h1234});
        step(0, 0, 1, 16'h8888);
        check_eq("R3", {out_valid, out_data}, {1'b0, 16'h1234});
        // R4: command with slot in same cycle uses old mode
        step(1, 1, 1, 16'h5555);
        check_eq("R4", {out_valid, out_data}, {1'b1, 16'h5555});
        // R5/R10: next slot is the seed, normal input ignored
        step(0, 1, 1, 16'h7777);
        check_eq("R5", {out_valid, out_data}, {1'b1, SEED});
        // R9: gaps do not disturb the sequence
        repeat (5) step(0, 0, 1, 16'h1111);
        check_eq("R9", {out_valid, out_data}, {1'b0, SEED});
        step(0, 1, 0, 16'h0);
        check_eq("R9", {out_valid, out_data}, {1'b1, nxt(SEED)});
        step(0, 0, 0, 16'h0);
        step(0, 1, 1, 16'hFFFF);
        check_eq("R10", {out_valid, out_data}, {1'b1, nxt(nxt(SEED))});
        // R8: stop then normal data at next slot
        step(1, 0, 0, 16'h0);
        step(0, 1, 1, 16'h2222);
        check_eq("R8", {out_valid, out_data}, {1'b1, 16'h2222});
        // R8: restart from the seed
        step(1, 0, 0, 16'h0);
        step(0, 1, 0, 16'h0);
        check_eq("R8", {out_valid, out_data}, {1'b1, SEED});
        // R7: full period in consecutive slots
        first_ret = 0;
        for (int k = 2; k <= 65536; k++) begin
            step(0, 1, $urandom_range(0, 1), 16'($urandom));
            if (first_ret == 0 && out_data == SEED) first_ret = k;
        end
        check_eq("R7", {1'b0, 16'(first_ret)}, {1'b0, 16'(65536 & 16'hFFFF)});
        if (first_ret != 65536) begin
            n_errors++;
            $display("FAIL R7: seed returned at slot %0d expected 65536", first_ret);
        end
        n_checks++;
        // Random mixed phase (R2, R3, R4, R6, R8, R10)
        for (int i = 0; i < 6000; i++) begin
            step(($urandom_range(0, 39) == 0), $urandom_range(0, 1),
                 $urandom_range(0, 1), 16'($urandom));
        end
        // R1: reset returns to pass-through
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_eq("R1", {out_valid, out_data}, 17'h0);
        rst_n = 1'b1;
        m_req = 0; m_act = 0; m_valid = 0; m_data = '0; m_lfsr = SEED;
        step(0, 1, 1, 16'h4321);
        check_eq("R1", {out_valid, out_data}, {1'b1, 16'h4321});
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule